// File: doc/BRIEF.md
# Dual-Bus 8-Bit Processor Datapath

This block is the register-and-ALU core of a small 8-bit stored-program machine. It contains four general registers, a program counter, an instruction register, a memory address register, an ALU operand register and a one-bit zero register. Two internal multiplexed buses link them. The source bus takes one general register or the program counter. The result bus takes the ALU output, the source bus, or the word read from memory.

An external sequencer drives every register load, every bus select and the ALU opcode, one cycle at a time. In return the block gives the sequencer the instruction register and the zero flag. The memory address comes from the address register. Memory write data is the source bus itself, with no register in between. The ALU always takes operand A from the operand register and operand B from the source bus. Because of this, one cycle can read two values: a value staged in the operand register and a value picked by the source bus.

Top module: `dualbus_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, every register clears to 0. This covers the general registers, program counter, instruction register, address register, operand register and zero flag.
- R2: `sel_src` picks the source-bus value. Codes 0 to 3 pick general registers 0 to 3, code 4 picks the program counter, and codes 5 to 7 give 0. `mem_wdata` always equals the source-bus value.
- R3: `sel_res` picks the result-bus value. Code 0 is the ALU output, code 1 is the source bus, code 2 is `mem_rdata`, and code 3 gives 0.
- R4: General register i takes the result-bus value at a rising edge only when `ld_gpr[i]` is high. Otherwise it keeps its value.
- R5: The instruction register takes the result-bus value when `ld_ir` is high and otherwise holds. `ir_q` shows it.
- R6: The address register takes the result-bus value when `ld_mar` is high and otherwise holds. `mem_addr` shows it.
- R7: The operand register takes the result-bus value when `ld_y` is high and otherwise holds. It is ALU operand A. ALU operand B is the source bus.
- R8: The ALU opcode encoding is as follows. 1 gives A+B modulo 256. 2 gives B−A modulo 256. 3 gives A&B. 4 gives ~A. Every other code gives 0.
- R9: When `ld_z` is high, the zero register records whether the ALU output equals 0. When `ld_z` is low, it holds.
- R10: When `ld_pc` is high, the program counter loads the result-bus value. When only `inc_pc` is high, it adds one, wrapping from 255 to 0. If both are high, the load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_gpr | input | 4 | Per-register load enables for the general registers |
| ld_pc | input | 1 | Load program counter from result bus |
| inc_pc | input | 1 | Increment program counter |
| ld_ir | input | 1 | Load instruction register |
| ld_mar | input | 1 | Load memory address register |
| ld_y | input | 1 | Load ALU operand register |
| ld_z | input | 1 | Capture zero flag |
| sel_src | input | 3 | Source-bus select |
| sel_res | input | 2 | Result-bus select |
| alu_op | input | 4 | ALU opcode |
| mem_rdata | input | 8 | Word read from memory |
| mem_addr | output | 8 | Memory address (address register) |
| mem_wdata | output | 8 | Memory write data (source bus) |
| ir_q | output | 8 | Instruction register contents |
| zero_q | output | 1 | Zero flag |

## Verification
Two pairs of functions can meet in one edge. The first pair is a program-counter load and an increment. The bench raises `ld_pc` and `inc_pc` together and checks that the loaded value appears on the source bus, not the incremented count. The second pair is a register that is written while it also feeds the source bus. Loading general register 0 from an ALU result computed on register 0 must use the old value during that cycle and the new value only after the edge. The ALU cases come from a vector table. Their results pass through the result bus into the instruction register, which makes them visible.

// File: rtl/dbp_pkg.sv
package dbp_pkg;
   // result-bus select codes
   localparam logic [1:0] RES_ALU = 2'd0;
   localparam logic [1:0] RES_SRC = 2'd1;
   localparam logic [1:0] RES_MEM = 2'd2;

   typedef enum logic [3:0] {
      OP_ADD = 4'h1,
      OP_SUB = 4'h2,
      OP_AND = 4'h3,
      OP_NOT = 4'h4
   } alu_op_e;
endpackage

// File: rtl/dbp_alu.sv
module dbp_alu #(
   parameter int W = 8
) (
   input  logic [3:0]   op,
   input  logic [W-1:0] opa,
   input  logic [W-1:0] opb,
   output logic [W-1:0] res
);
   import dbp_pkg::*;

   always_comb begin
      case (op)
         OP_ADD:  res = opa + opb;
         OP_SUB:  res = opb - opa;
         OP_AND:  res = opa & opb;
         OP_NOT:  res = ~opa;
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/dbp_gpr_bank.sv
module dbp_gpr_bank #(
   parameter int W = 8,
   parameter int N = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [N-1:0]       ld,
   input  logic [W-1:0]       din,
   output logic [N-1:0][W-1:0] q
);
   for (genvar i = 0; i < N; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst)        q[i] <= '0;
         else if (ld[i]) q[i] <= din;
      end

      // R4
      gpr_hold_chk: assert property (@(posedge clk) disable iff (rst)
         !ld[i] |=> $stable(q[i]));
      // R4
      gpr_load_chk: assert property (@(posedge clk) disable iff (rst)
         ld[i] |=> q[i] == $past(din));
   end
endmodule

// File: rtl/dbp_src_mux.sv
module dbp_src_mux #(
   parameter int W     = 8,
   parameter int N     = 4,
   parameter int SEL_W = 3
) (
   input  logic [SEL_W-1:0]    sel,
   input  logic [N-1:0][W-1:0] gpr,
   input  logic [W-1:0]        pc,
   output logic [W-1:0]        bus
);
   always_comb begin
      bus = '0;
      for (int i = 0; i < N; i++) begin
         if (sel == SEL_W'(i)) bus = gpr[i];
      end
      if (sel == SEL_W'(N)) bus = pc;
   end
endmodule

// File: rtl/dbp_ctrl_regs.sv
module dbp_ctrl_regs #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] res_bus,
   input  logic [W-1:0] alu_res,
   input  logic         ld_pc,
   input  logic         inc_pc,
   input  logic         ld_ir,
   input  logic         ld_mar,
   input  logic         ld_y,
   input  logic         ld_z,
   output logic [W-1:0] pc_q,
   output logic [W-1:0] ir_q,
   output logic [W-1:0] mar_q,
   output logic [W-1:0] y_q,
   output logic         z_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q  <= '0;
         ir_q  <= '0;
         mar_q <= '0;
         y_q   <= '0;
         z_q   <= 1'b0;
      end else begin
         if (ld_pc)       pc_q <= res_bus;
         else if (inc_pc) pc_q <= pc_q + 1'b1;
         if (ld_ir)  ir_q  <= res_bus;
         if (ld_mar) mar_q <= res_bus;
         if (ld_y)   y_q   <= res_bus;
         if (ld_z)   z_q   <= (alu_res == '0);
      end
   end

   // R10
   pc_load_chk: assert property (@(posedge clk) disable iff (rst)
      ld_pc |=> pc_q == $past(res_bus));
   // R10
   pc_inc_chk: assert property (@(posedge clk) disable iff (rst)
      (!ld_pc && inc_pc) |=> pc_q == W'($past(pc_q) + 1'b1));
   // R10
   pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!ld_pc && !inc_pc) |=> $stable(pc_q));
   // R5
   ir_load_chk: assert property (@(posedge clk) disable iff (rst)
      ld_ir |=> ir_q == $past(res_bus));
   // R6
   mar_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !ld_mar |=> $stable(mar_q));
   // R7
   y_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !ld_y |=> $stable(y_q));
   // R9
   zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !ld_z |=> $stable(z_q));
   // R9
   zero_set_chk: assert property (@(posedge clk) disable iff (rst)
      (ld_z && $countones(alu_res) == 0) |=> z_q);
endmodule

// File: rtl/dualbus_datapath.sv
module dualbus_datapath #(
   parameter int DATA_W  = 8,
   parameter int NUM_GPR = 4,
   parameter int OPC_W   = 4,
   localparam int SRC_W  = $clog2(NUM_GPR + 1)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_GPR-1:0] ld_gpr,
   input  logic               ld_pc,
   input  logic               inc_pc,
   input  logic               ld_ir,
   input  logic               ld_mar,
   input  logic               ld_y,
   input  logic               ld_z,
   input  logic [SRC_W-1:0]   sel_src,
   input  logic [1:0]         sel_res,
   input  logic [OPC_W-1:0]   alu_op,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic [DATA_W-1:0]  mem_addr,
   output logic [DATA_W-1:0]  mem_wdata,
   output logic [DATA_W-1:0]  ir_q,
   output logic               zero_q
);
   import dbp_pkg::*;

   if (DATA_W < 2) begin : g_bad_w
      $error("DATA_W must be at least 2");
   end
   if (NUM_GPR < 1) begin : g_bad_n
      $error("NUM_GPR must be at least 1");
   end
   if (OPC_W != 4) begin : g_bad_op
      $error("OPC_W must be 4");
   end

   logic [NUM_GPR-1:0][DATA_W-1:0] gpr_q;
   logic [DATA_W-1:0] src_bus, res_bus, alu_res, pc_q, y_q;

   dbp_gpr_bank #(.W(DATA_W), .N(NUM_GPR)) u_gpr (
      .clk(clk), .rst(rst), .ld(ld_gpr), .din(res_bus), .q(gpr_q));

   dbp_src_mux #(.W(DATA_W), .N(NUM_GPR), .SEL_W(SRC_W)) u_src (
      .sel(sel_src), .gpr(gpr_q), .pc(pc_q), .bus(src_bus));

   dbp_alu #(.W(DATA_W)) u_alu (
      .op(alu_op), .opa(y_q), .opb(src_bus), .res(alu_res));

   always_comb begin
      case (sel_res)
         RES_ALU: res_bus = alu_res;
         RES_SRC: res_bus = src_bus;
         RES_MEM: res_bus = mem_rdata;
         default: res_bus = '0;
      endcase
   end

   dbp_ctrl_regs #(.W(DATA_W)) u_ctl (
      .clk(clk), .rst(rst), .res_bus(res_bus), .alu_res(alu_res),
      .ld_pc(ld_pc), .inc_pc(inc_pc), .ld_ir(ld_ir), .ld_mar(ld_mar),
      .ld_y(ld_y), .ld_z(ld_z), .pc_q(pc_q), .ir_q(ir_q),
      .mar_q(mem_addr), .y_q(y_q), .z_q(zero_q));

   assign mem_wdata = src_bus;

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (ir_q == '0 && mem_addr == '0 && !zero_q));
   // R6
   mar_load_chk: assert property (@(posedge clk) disable iff (rst)
      ld_mar |=> mem_addr == $past(res_bus));
endmodule

// File: tb/sim_dualbus_datapath.sv
`timescale 1ns/1ps
module sim_dualbus_datapath;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [3:0] ld_gpr = '0;
   logic ld_pc = 0, inc_pc = 0, ld_ir = 0, ld_mar = 0, ld_y = 0, ld_z = 0;
   logic [2:0] sel_src = '0;
   logic [1:0] sel_res = '0;
   logic [3:0] alu_op = '0;
   logic [7:0] mem_rdata = '0;
   logic [7:0] mem_addr, mem_wdata, ir_q;
   logic zero_q;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #10 clk = ~clk;

   dualbus_datapath u0 (
      .clk(clk), .rst(rst), .ld_gpr(ld_gpr), .ld_pc(ld_pc), .inc_pc(inc_pc),
      .ld_ir(ld_ir), .ld_mar(ld_mar), .ld_y(ld_y), .ld_z(ld_z),
      .sel_src(sel_src), .sel_res(sel_res), .alu_op(alu_op),
      .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .ir_q(ir_q), .zero_q(zero_q));

   // {op, y, b, expected}
   localparam logic [27:0] VEC [10] = '{
      {4'h1, 8'h12, 8'h34, 8'h46},
      {4'h1, 8'hFF, 8'h01, 8'h00},
      {4'h2, 8'h05, 8'h03, 8'hFE},
      {4'h2, 8'h40, 8'h40, 8'h00},
      {4'h3, 8'hF0, 8'h3C, 8'h30},
      {4'h3, 8'h0F, 8'hF0, 8'h00},
      {4'h4, 8'h5A, 8'h00, 8'hA5},
      {4'h4, 8'hFF, 8'h77, 8'h00},
      {4'h0, 8'h11, 8'h22, 8'h00},
      {4'hF, 8'h11, 8'h22, 8'h00}};

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      ld_gpr = '0; ld_pc = 0; inc_pc = 0; ld_ir = 0;
      ld_mar = 0; ld_y = 0; ld_z = 0;
   endtask

   task automatic put_gpr(int i, logic [7:0] v);
      sel_res = 2'd2; mem_rdata = v; ld_gpr = 4'(1 << i); tick();
   endtask

   task automatic put_y(logic [7:0] v);
      sel_res = 2'd2; mem_rdata = v; ld_y = 1; tick();
   endtask

   task automatic put_pc(logic [7:0] v);
      sel_res = 2'd2; mem_rdata = v; ld_pc = 1; tick();
   endtask

   task automatic src_val(logic [2:0] s, output logic [7:0] v);
      sel_src = s; #1; v = mem_wdata;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst = 0;
      #1;
      // R1 reset state
      check("R1", ir_q, 8'h00);
      check("R1", mem_addr, 8'h00);
      check("R1", {7'd0, zero_q}, 8'h00);
      for (int s = 0; s < 5; s++) begin
         src_val(3'(s), v); check("R1", v, 8'h00);
      end

      // R8 R9 vector walk: result travels result bus -> IR
      for (int k = 0; k < 10; k++) begin
         put_gpr(1, VEC[k][15:8]);
         put_y(VEC[k][23:16]);
         sel_src = 3'd1; alu_op = VEC[k][27:24]; sel_res = 2'd0;
         ld_ir = 1; ld_z = 1; tick();
         check("R8", ir_q, VEC[k][7:0]);
         check("R9", {7'd0, zero_q}, {7'd0, VEC[k][7:0] == 8'h00});
      end

      // R2 source select map
      put_gpr(0, 8'h11); put_gpr(1, 8'h22); put_gpr(2, 8'h33); put_gpr(3, 8'h44);
      put_pc(8'h55);
      for (int s = 0; s < 8; s++) begin
         src_val(3'(s), v);
         check("R2", v, s < 4 ? 8'(8'h11 * (s + 1)) : (s == 4 ? 8'h55 : 8'h00));
      end

      // R3 result select map into IR
      sel_src = 3'd2; sel_res = 2'd1; ld_ir = 1; tick(); check("R3", ir_q, 8'h33);
      mem_rdata = 8'h9C; sel_res = 2'd2; ld_ir = 1; tick(); check("R3", ir_q, 8'h9C);
      sel_res = 2'd3; ld_ir = 1; tick(); check("R3", ir_q, 8'h00);

      // R5 IR holds without load
      mem_rdata = 8'hEE; sel_res = 2'd2; tick(); check("R5", ir_q, 8'h00);

      // R4 no load -> unchanged
      mem_rdata = 8'hBB; sel_res = 2'd2; tick();
      src_val(3'd3, v); check("R4", v, 8'h44);

      // R6 MAR load and hold
      mem_rdata = 8'h7E; sel_res = 2'd2; ld_mar = 1; tick(); check("R6", mem_addr, 8'h7E);
      mem_rdata = 8'h01; tick(); check("R6", mem_addr, 8'h7E);

      // R4 R7 register read and written in same cycle: R0 <- Y + R0
      put_y(8'h01);
      sel_src = 3'd0; alu_op = 4'h1; sel_res = 2'd0; ld_gpr = 4'b0001; #1;
      check("R7", mem_wdata, 8'h11);
      tick();
      src_val(3'd0, v); check("R4", v, 8'h12);
      // R7 Y holds without load
      mem_rdata = 8'h80; sel_res = 2'd2; tick();
      sel_src = 3'd0; alu_op = 4'h4; sel_res = 2'd0; ld_ir = 1; tick();
      check("R7", ir_q, 8'hFE);

      // R9 zero flag holds when ld_z low (ALU output is 0 here)
      put_y(8'h00);
      alu_op = 4'h3; sel_src = 3'd0; ld_z = 1; tick();
      check("R9", {7'd0, zero_q}, 8'h01);
      put_y(8'h0F); alu_op = 4'h3; sel_src = 3'd0; ld_z = 1; tick();
      check("R9", {7'd0, zero_q}, 8'h00);
      put_y(8'h00); alu_op = 4'h3; tick();
      check("R9", {7'd0, zero_q}, 8'h00);

      // R10 increment wrap, then load beats increment
      put_pc(8'hFF);
      inc_pc = 1; tick();
      src_val(3'd4, v); check("R10", v, 8'h00);
      inc_pc = 1; tick();
      src_val(3'd4, v); check("R10", v, 8'h01);
      mem_rdata = 8'hA0; sel_res = 2'd2; ld_pc = 1; inc_pc = 1; tick();
      src_val(3'd4, v); check("R10", v, 8'hA0);

      // R1 reset mid-run clears everything
      rst = 1; tick(); rst = 0; #1;
      check("R1", ir_q, 8'h00);
      check("R1", mem_addr, 8'h00);
      src_val(3'd0, v); check("R1", v, 8'h00);
      src_val(3'd4, v); check("R1", v, 8'h00);

      finish_run();
   end
endmodule